// File: doc/BRIEF.md
# Page Permission and Protection-Key Checker

This block sits at the tail of an address-translation path. After a table walker has found a leaf entry and merged the user, writable and no-execute bits along the path, the checker decides whether the requested access may go ahead. It takes the access kind (read, write or instruction fetch), the privilege of the requester and the paging control enables. From these it produces three things: the read/write/execute rights that a TLB may cache, a pass or fail verdict, and either the leaf entry with its accessed and dirty flags updated or a page-fault error code.

Write protection, supervisor execution prevention and a supervisor-access-checked mode are applied. Protection keys are also applied to user and supervisor pages, each class using its own key-rights register. In long mode the virtual address is tested for canonical form first, and a failure there is reported as a general-protection condition, not as a page fault. All results are registered, so a response appears one clock after its request.

Top module: `pg_perm_check`

## Requirements
- R1: A request with `req_valid` high yields `rsp_valid` high on the next clock edge and only then; synchronous reset clears `rsp_valid` and `rsp_pass`.
- R2: A user access (`req_user`=1) to a page whose merged user bit is clear fails with error bits 0 and 2 set.
- R3: Read right (`rsp_prot` bit 0) is granted except when a supervisor access in the access-checked mode (`req_sup_chk`=1) targets a user page. In that case write right is also denied.
- R4: Write right (`rsp_prot` bit 1) is granted when the merged writable bit is set, or when the access is supervisor and write protection is off.
- R5: Execute right (`rsp_prot` bit 2) is granted when the merged no-execute bit is clear. The exception is that, with execution prevention on, a supervisor fetch from a user page is denied.
- R6: The key index is leaf entry bits 62:59. A user page takes its rights from the user key register, and only when that key class is enabled; a supervisor page takes them from the supervisor register. For key k, bit 2k is access-disable, and it removes read and write rights.
- R7: Key bit 2k+1 (write-disable) removes write right only for user accesses or while write protection is on.
- R8: A failure caused by the key rights sets error bit 5 along with bit 0.
- R9: A permitted access returns the entry with the accessed bit (bit 5) set, and for a write also the dirty bit (bit 6). If the returned entry is not dirty, write right is cleared from `rsp_prot`.
- R10: Error bit 1 marks a write and bit 2 a user access. Bit 4 marks a fetch, but only when no-execute or execution prevention is enabled.
- R11: A reserved-bit fault flagged by the walker fails with error bits 3 and 0 set.
- R12: With long mode on, an address whose bits above bit 47 (bit 56 when 5-level paging is on) do not all equal that bit gives `rsp_gp`=1, no pass, a zero error code and zero rights.
- R13: Access code 0 is read, 1 is write, 2 is fetch; code 3 is handled as a read. On any failure `rsp_prot` is zero and `rsp_entry` equals the input entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | Requester is in user mode |
| req_sup_chk | input | 1 | Supervisor access-checked mode |
| leaf_user | input | 1 | Merged user bit of the walk |
| leaf_rw | input | 1 | Merged writable bit of the walk |
| leaf_nx | input | 1 | Merged no-execute bit of the walk |
| leaf_entry | input | ENTRY_W | Leaf entry as read from memory |
| leaf_rsvd | input | 1 | Walker found a reserved-bit violation |
| vaddr | input | VA_W | Virtual address of the access |
| wp_en | input | 1 | Write protection enable |
| nx_en | input | 1 | No-execute enable |
| smep_en | input | 1 | Supervisor execution prevention enable |
| long_en | input | 1 | Long mode active |
| la57_en | input | 1 | 5-level paging active |
| ukey_en | input | 1 | User-page key checking enable |
| skey_en | input | 1 | Supervisor-page key checking enable |
| ukey_reg | input | 2*2^KEY_W | User key rights |
| skey_reg | input | 2*2^KEY_W | Supervisor key rights |
| rsp_valid | output | 1 | Response strobe |
| rsp_pass | output | 1 | Access permitted |
| rsp_gp | output | 1 | Non-canonical address |
| rsp_prot | output | 3 | Rights mask: bit 0 read, bit 1 write, bit 2 execute |
| rsp_err | output | 6 | Page-fault error code |
| rsp_entry | output | ENTRY_W | Entry with accessed/dirty update |

## Verification
The bench builds the block with its default parameters: 64-bit entries and addresses, a 4-bit key at bit 59, and canonical boundaries at bits 47 and 56. With these values, a key index that selects a pair in the middle of a 32-bit rights register can be tested against a neighbouring index. An address that is canonical under 5-level paging but not under 4-level paging can also be built, so both sign boundaries are tested against the same pattern.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;

    localparam int ENT_ACC_BIT   = 5;
    localparam int ENT_DIRTY_BIT = 6;

    typedef logic [2:0] rights_t;

    // error code, bit 0 at the right
    typedef struct packed {
        logic key;
        logic fetch;
        logic rsvd;
        logic user;
        logic write;
        logic prot;
    } ecode_t;

    typedef struct packed {
        logic    pass;
        logic    gp;
        rights_t rights;
        ecode_t  ecode;
    } verdict_t;

    function automatic acc_e acc_norm(input logic [1:0] raw);
        acc_e a;
        a = acc_e'(raw);
        if (a == ACC_ALT) a = ACC_READ;
        return a;
    endfunction

    function automatic int acc_idx(input acc_e a);
        case (a)
            ACC_WRITE: return RIGHT_W;
            ACC_FETCH: return RIGHT_X;
            default:   return RIGHT_R;
        endcase
    endfunction

endpackage

// File: rtl/pgc_canon.sv
module pgc_canon #(
    parameter int VA_W   = 64,
    parameter int LO_TOP = 47,
    parameter int HI_TOP = 56
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            long_en,
    input  logic            la57_en,
    output logic            noncanon
);
    localparam logic [VA_W-1:0] LO_MASK = {VA_W{1'b1}} << LO_TOP;
    localparam logic [VA_W-1:0] HI_MASK = {VA_W{1'b1}} << HI_TOP;

    logic [VA_W-1:0] sel_mask;
    logic [VA_W-1:0] upper;

    always_comb begin
        sel_mask = la57_en ? HI_MASK : LO_MASK;
        upper    = vaddr & sel_mask;
        noncanon = long_en && (upper != '0) && (upper != sel_mask);
    end
endmodule

// File: rtl/pgc_rights.sv
module pgc_rights
    import pgc_pkg::*;
(
    input  logic    is_user,
    input  logic    sup_chk,
    input  logic    pg_user,
    input  logic    pg_rw,
    input  logic    pg_nx,
    input  logic    wp_en,
    input  logic    smep_en,
    output rights_t rights
);
    logic data_ok;

    always_comb begin
        rights  = '0;
        data_ok = !(sup_chk && !is_user && pg_user);
        if (data_ok) begin
            rights[RIGHT_R] = 1'b1;
            rights[RIGHT_W] = pg_rw || (!is_user && !wp_en);
        end
        rights[RIGHT_X] = !pg_nx && (is_user || !(smep_en && pg_user));
    end
endmodule

// File: rtl/pgc_pkey.sv
module pgc_pkey
    import pgc_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0]           key,
    input  logic                       pg_user,
    input  logic                       is_user,
    input  logic                       wp_en,
    input  logic                       ukey_en,
    input  logic                       skey_en,
    input  logic [2*(1<<KEY_W)-1:0]    ukey_reg,
    input  logic [2*(1<<KEY_W)-1:0]    skey_reg,
    output logic                       active,
    output rights_t                    krights
);
    localparam int REG_W = 2 * (1 << KEY_W);

    logic [REG_W-1:0] rights_reg;
    logic [REG_W-1:0] shifted;
    logic             deny_all;
    logic             deny_wr;

    always_comb begin
        if (pg_user) rights_reg = ukey_en ? ukey_reg : '0;
        else         rights_reg = skey_en ? skey_reg : '0;
        active   = |rights_reg;
        shifted  = rights_reg >> {key, 1'b0};
        deny_all = shifted[0];
        deny_wr  = shifted[1];
        krights  = 3'b111;
        if (deny_all) begin
            krights[RIGHT_R] = 1'b0;
            krights[RIGHT_W] = 1'b0;
        end else if (deny_wr && (is_user || wp_en)) begin
            krights[RIGHT_W] = 1'b0;
        end
    end
endmodule

// File: rtl/pgc_judge.sv
module pgc_judge
    import pgc_pkg::*;
#(
    parameter int ENTRY_W = 64
) (
    input  acc_e               acc,
    input  logic               is_user,
    input  logic               pg_user,
    input  logic               noncanon,
    input  logic               rsvd_hit,
    input  rights_t            base,
    input  logic               key_active,
    input  rights_t            krights,
    input  logic               nx_en,
    input  logic               smep_en,
    input  logic [ENTRY_W-1:0] entry_in,
    output verdict_t           verdict,
    output logic [ENTRY_W-1:0] entry_out
);
    rights_t merged;
    logic    fail_prot;
    logic    fail_rsvd;
    logic    fail_key;
    int      idx;

    always_comb begin
        verdict   = '0;
        entry_out = entry_in;
        fail_prot = 1'b0;
        fail_rsvd = 1'b0;
        fail_key  = 1'b0;
        idx       = acc_idx(acc);
        merged    = key_active ? (base & krights) : base;

        if (noncanon) begin
            verdict.gp = 1'b1;
        end else if (rsvd_hit) begin
            fail_rsvd = 1'b1;
        end else if (is_user && !pg_user) begin
            fail_prot = 1'b1;
        end else if (key_active && !krights[idx]) begin
            fail_prot = 1'b1;
            fail_key  = 1'b1;
        end else if (!merged[idx]) begin
            fail_prot = 1'b1;
        end else begin
            verdict.pass = 1'b1;
            entry_out[ENT_ACC_BIT] = 1'b1;
            if (acc == ACC_WRITE) entry_out[ENT_DIRTY_BIT] = 1'b1;
            verdict.rights = merged;
            if (!entry_out[ENT_DIRTY_BIT]) verdict.rights[RIGHT_W] = 1'b0;
        end

        if (fail_prot || fail_rsvd) begin
            verdict.ecode.prot  = 1'b1;
            verdict.ecode.rsvd  = fail_rsvd;
            verdict.ecode.key   = fail_key;
            verdict.ecode.write = (acc == ACC_WRITE);
            verdict.ecode.user  = is_user;
            verdict.ecode.fetch = (acc == ACC_FETCH) && (nx_en || smep_en);
        end
    end
endmodule

// File: rtl/pg_perm_check.sv
module pg_perm_check
    import pgc_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int VA_W    = 64,
    parameter int KEY_W   = 4,
    parameter int KEY_LSB = 59,
    parameter int LO_TOP  = 47,
    parameter int HI_TOP  = 56
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_acc,
    input  logic                    req_user,
    input  logic                    req_sup_chk,
    input  logic                    leaf_user,
    input  logic                    leaf_rw,
    input  logic                    leaf_nx,
    input  logic [ENTRY_W-1:0]      leaf_entry,
    input  logic                    leaf_rsvd,
    input  logic [VA_W-1:0]         vaddr,
    input  logic                    wp_en,
    input  logic                    nx_en,
    input  logic                    smep_en,
    input  logic                    long_en,
    input  logic                    la57_en,
    input  logic                    ukey_en,
    input  logic                    skey_en,
    input  logic [2*(1<<KEY_W)-1:0] ukey_reg,
    input  logic [2*(1<<KEY_W)-1:0] skey_reg,
    output logic                    rsp_valid,
    output logic                    rsp_pass,
    output logic                    rsp_gp,
    output logic [2:0]              rsp_prot,
    output logic [5:0]              rsp_err,
    output logic [ENTRY_W-1:0]      rsp_entry
);
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    acc_e               acc;
    logic               noncanon;
    rights_t            base;
    rights_t            krights;
    logic               key_active;
    verdict_t           verdict;
    logic [ENTRY_W-1:0] entry_nxt;

    assign acc = acc_norm(req_acc);

    pgc_canon #(.VA_W(VA_W), .LO_TOP(LO_TOP), .HI_TOP(HI_TOP)) u_canon (
        .vaddr    (vaddr),
        .long_en  (long_en),
        .la57_en  (la57_en),
        .noncanon (noncanon)
    );

    pgc_rights u_rights (
        .is_user (req_user),
        .sup_chk (req_sup_chk),
        .pg_user (leaf_user),
        .pg_rw   (leaf_rw),
        .pg_nx   (leaf_nx),
        .wp_en   (wp_en),
        .smep_en (smep_en),
        .rights  (base)
    );

    pgc_pkey #(.KEY_W(KEY_W)) u_pkey (
        .key      (leaf_entry[KEY_MSB:KEY_LSB]),
        .pg_user  (leaf_user),
        .is_user  (req_user),
        .wp_en    (wp_en),
        .ukey_en  (ukey_en),
        .skey_en  (skey_en),
        .ukey_reg (ukey_reg),
        .skey_reg (skey_reg),
        .active   (key_active),
        .krights  (krights)
    );

    pgc_judge #(.ENTRY_W(ENTRY_W)) u_judge (
        .acc        (acc),
        .is_user    (req_user),
        .pg_user    (leaf_user),
        .noncanon   (noncanon),
        .rsvd_hit   (leaf_rsvd),
        .base       (base),
        .key_active (key_active),
        .krights    (krights),
        .nx_en      (nx_en),
        .smep_en    (smep_en),
        .entry_in   (leaf_entry),
        .verdict    (verdict),
        .entry_out  (entry_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pass  <= 1'b0;
            rsp_gp    <= 1'b0;
            rsp_prot  <= '0;
            rsp_err   <= '0;
            rsp_entry <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pass  <= verdict.pass;
                rsp_gp    <= verdict.gp;
                rsp_prot  <= verdict.rights;
                rsp_err   <= verdict.ecode;
                rsp_entry <= entry_nxt;
            end
        end
    end
endmodule

// File: rtl/pgc_check.sv
module pgc_check
    import pgc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_acc,
    input logic       req_user,
    input logic       leaf_user,
    input logic       leaf_rsvd,
    input logic       long_en,
    input logic       nx_en,
    input logic       smep_en,
    input logic       rsp_valid,
    input logic       rsp_pass,
    input logic       rsp_gp,
    input logic [2:0] rsp_prot,
    input logic [5:0] rsp_err,
    input logic       rsp_acc_bit,
    input logic       rsp_dirty_bit
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    user_on_sup_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user && !leaf_user && !long_en && !leaf_rsvd)
        |=> (!rsp_pass && rsp_err[0] && rsp_err[2]));

    // R8
    key_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err[5]) |-> (rsp_err[0] && !rsp_pass));

    // R9
    accessed_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pass) |-> rsp_acc_bit);

    // R9
    write_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_acc == ACC_WRITE) |=> (!rsp_pass || rsp_dirty_bit));

    // R9
    clean_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pass && !rsp_dirty_bit) |-> !rsp_prot[RIGHT_W]);

    // R10
    fetch_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !nx_en && !smep_en) |=> !rsp_err[4]);

    // R11
    rsvd_code_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err[3]) |-> rsp_err[0]);

    // R12
    gp_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_gp) |-> (!rsp_pass && rsp_err == 6'd0 && rsp_prot == 3'd0));

    // R13
    fail_no_rights_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_pass) |-> (rsp_prot == 3'd0));
endmodule

bind pg_perm_check pgc_check u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_acc       (req_acc),
    .req_user      (req_user),
    .leaf_user     (leaf_user),
    .leaf_rsvd     (leaf_rsvd),
    .long_en       (long_en),
    .nx_en         (nx_en),
    .smep_en       (smep_en),
    .rsp_valid     (rsp_valid),
    .rsp_pass      (rsp_pass),
    .rsp_gp        (rsp_gp),
    .rsp_prot      (rsp_prot),
    .rsp_err       (rsp_err),
    .rsp_acc_bit   (rsp_entry[pgc_pkg::ENT_ACC_BIT]),
    .rsp_dirty_bit (rsp_entry[pgc_pkg::ENT_DIRTY_BIT])
);

// File: tb/tb_pg_perm_check.sv
module tb_pg_perm_check;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        req_sup_chk = 1'b0;
    logic        leaf_user = 1'b0;
    logic        leaf_rw = 1'b0;
    logic        leaf_nx = 1'b0;
    logic [63:0] leaf_entry = '0;
    logic        leaf_rsvd = 1'b0;
    logic [63:0] vaddr = '0;
    logic        wp_en = 1'b0;
    logic        nx_en = 1'b1;
    logic        smep_en = 1'b0;
    logic        long_en = 1'b0;
    logic        la57_en = 1'b0;
    logic        ukey_en = 1'b0;
    logic        skey_en = 1'b0;
    logic [31:0] ukey_reg = '0;
    logic [31:0] skey_reg = '0;
    logic        rsp_valid;
    logic        rsp_pass;
    logic        rsp_gp;
    logic [2:0]  rsp_prot;
    logic [5:0]  rsp_err;
    logic [63:0] rsp_entry;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic        pass;
        logic        gp;
        logic [2:0]  prot;
        logic [5:0]  err;
        logic [63:0] entry;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_perm_check dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_acc(req_acc),
        .req_user(req_user), .req_sup_chk(req_sup_chk), .leaf_user(leaf_user),
        .leaf_rw(leaf_rw), .leaf_nx(leaf_nx), .leaf_entry(leaf_entry),
        .leaf_rsvd(leaf_rsvd), .vaddr(vaddr), .wp_en(wp_en), .nx_en(nx_en),
        .smep_en(smep_en), .long_en(long_en), .la57_en(la57_en),
        .ukey_en(ukey_en), .skey_en(skey_en), .ukey_reg(ukey_reg),
        .skey_reg(skey_reg), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
        .rsp_gp(rsp_gp), .rsp_prot(rsp_prot), .rsp_err(rsp_err),
        .rsp_entry(rsp_entry)
    );

    // entry with present bit only; key field and flags are added per case
    localparam logic [63:0] E0   = 64'h0000_0000_0012_3001;
    localparam logic [63:0] EA   = 64'h0000_0000_0012_3021;
    localparam logic [63:0] EAD  = 64'h0000_0000_0012_3061;
    localparam logic [63:0] KEY3 = 64'h1800_0000_0000_0000;
    localparam logic [63:0] KEY2 = 64'h1000_0000_0000_0000;

    task automatic send(input string tag, input logic [1:0] acc, input logic usr,
                        input logic pu, input logic prw, input logic pnx,
                        input logic [63:0] ent, input logic xpass, input logic xgp,
                        input logic [2:0] xprot, input logic [5:0] xerr,
                        input logic [63:0] xent);
        exp_t e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_acc    = acc;
        req_user   = usr;
        leaf_user  = pu;
        leaf_rw    = prw;
        leaf_nx    = pnx;
        leaf_entry = ent;
        e.tag = tag; e.pass = xpass; e.gp = xgp; e.prot = xprot;
        e.err = xerr; e.entry = xent;
        sb.push_back(e);
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_pass !== e.pass || rsp_gp !== e.gp || rsp_prot !== e.prot ||
                    rsp_err !== e.err || rsp_entry !== e.entry) begin
                    errors++;
                    $display("FAIL %s: actual pass=%0b gp=%0b prot=%03b err=%06b entry=%h expected pass=%0b gp=%0b prot=%03b err=%06b entry=%h",
                             e.tag, rsp_pass, rsp_gp, rsp_prot, rsp_err, rsp_entry,
                             e.pass, e.gp, e.prot, e.err, e.entry);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_pass !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual valid=%0b pass=%0b expected 0 0", rsp_valid, rsp_pass);
        end

        // R3 supervisor read, clean entry: W dropped
        send("R3 sup read", 2'd0, 0, 1, 1, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        // R9 write sets accessed and dirty
        send("R9 sup write", 2'd1, 0, 1, 1, 0, E0, 1, 0, 3'b111, 6'd0, EAD);
        // R2 user on supervisor page
        send("R2 user read sup page", 2'd0, 1, 0, 1, 0, E0, 0, 0, 3'b000, 6'b000101, E0);
        // R4 supervisor write to read-only page, wp off
        send("R4 sup write wp off", 2'd1, 0, 0, 0, 0, E0, 1, 0, 3'b111, 6'd0, EAD);
        @(negedge clk); req_valid = 1'b0; wp_en = 1'b1;
        send("R4 sup write wp on", 2'd1, 0, 0, 0, 0, E0, 0, 0, 3'b000, 6'b000011, E0);
        @(negedge clk); req_valid = 1'b0; wp_en = 1'b0;
        send("R4 user write ro", 2'd1, 1, 1, 0, 0, E0, 0, 0, 3'b000, 6'b000111, E0);
        // R5 / R10 fetch from nx page
        send("R5 user fetch nx", 2'd2, 1, 1, 1, 1, E0, 0, 0, 3'b000, 6'b010101, E0);
        @(negedge clk); req_valid = 1'b0; nx_en = 1'b0;
        send("R10 fetch bit gated", 2'd2, 1, 1, 1, 1, E0, 0, 0, 3'b000, 6'b000101, E0);
        @(negedge clk); req_valid = 1'b0; smep_en = 1'b1;
        send("R5 smep sup fetch user page", 2'd2, 0, 1, 1, 0, E0, 0, 0, 3'b000, 6'b010001, E0);
        send("R5 smep sup fetch sup page", 2'd2, 0, 0, 1, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0; smep_en = 1'b0; nx_en = 1'b1; req_sup_chk = 1'b1;
        send("R3 checked read user page", 2'd0, 0, 1, 1, 0, E0, 0, 0, 3'b000, 6'b000001, E0);
        send("R3 checked fetch user page", 2'd2, 0, 1, 1, 0, E0, 1, 0, 3'b100, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0; req_sup_chk = 1'b0;
        ukey_en = 1'b1; ukey_reg = 32'h0000_0040;
        // R6 / R8 access-disable on key 3
        send("R6 R8 key AD read", 2'd0, 1, 1, 1, 0, E0 | KEY3, 0, 0, 3'b000, 6'b100101, E0 | KEY3);
        send("R6 key AD fetch", 2'd2, 1, 1, 1, 0, E0 | KEY3, 1, 0, 3'b100, 6'd0, EA | KEY3);
        send("R6 key index 2 free", 2'd0, 1, 1, 1, 0, E0 | KEY2, 1, 0, 3'b101, 6'd0, EA | KEY2);
        @(negedge clk); req_valid = 1'b0; ukey_reg = 32'h0000_0080;
        // R7 write-disable
        send("R7 key WD user write", 2'd1, 1, 1, 1, 0, E0 | KEY3, 0, 0, 3'b000, 6'b100111, E0 | KEY3);
        @(negedge clk); req_valid = 1'b0; skey_en = 1'b1; skey_reg = 32'h0000_0080;
        send("R7 key WD sup wp off", 2'd1, 0, 0, 1, 0, E0 | KEY3, 1, 0, 3'b111, 6'd0, EAD | KEY3);
        @(negedge clk); req_valid = 1'b0; wp_en = 1'b1;
        send("R7 key WD sup wp on", 2'd1, 0, 0, 1, 0, E0 | KEY3, 0, 0, 3'b000, 6'b100011, E0 | KEY3);
        @(negedge clk); req_valid = 1'b0; wp_en = 1'b0; skey_en = 1'b0; skey_reg = '0;
        ukey_en = 1'b0; ukey_reg = 32'h0000_0040;
        send("R6 user keys disabled", 2'd0, 1, 1, 1, 0, E0 | KEY3, 1, 0, 3'b101, 6'd0, EA | KEY3);
        @(negedge clk); req_valid = 1'b0; ukey_reg = '0;
        // R9 already dirty keeps write right on read
        send("R9 dirty read", 2'd0, 0, 1, 1, 0, 64'h0000_0000_0012_3041, 1, 0, 3'b111, 6'd0, EAD);
        @(negedge clk); req_valid = 1'b0; leaf_rsvd = 1'b1;
        send("R11 reserved fault", 2'd1, 1, 1, 1, 0, E0, 0, 0, 3'b000, 6'b001111, E0);
        @(negedge clk); req_valid = 1'b0; leaf_rsvd = 1'b0; long_en = 1'b1;
        vaddr = 64'h0000_8000_0000_0000;
        send("R12 noncanon 4-level", 2'd0, 0, 0, 1, 0, E0, 0, 1, 3'b000, 6'd0, E0);
        @(negedge clk); req_valid = 1'b0; vaddr = 64'hFFFF_8000_0000_0000;
        send("R12 canon high 4-level", 2'd0, 0, 0, 1, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0; la57_en = 1'b1; vaddr = 64'h0000_8000_0000_0000;
        send("R12 canon 5-level", 2'd0, 0, 0, 1, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0; vaddr = 64'h0100_0000_0000_0000;
        send("R12 noncanon 5-level", 2'd0, 0, 0, 1, 0, E0, 0, 1, 3'b000, 6'd0, E0);
        @(negedge clk); req_valid = 1'b0; long_en = 1'b0; la57_en = 1'b0;
        send("R12 long mode off", 2'd0, 0, 0, 1, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0; wp_en = 1'b1;
        // R13 code 3 behaves as read
        send("R13 code 3 as read", 2'd3, 0, 0, 0, 0, E0, 1, 0, 3'b101, 6'd0, EA);
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 missing responses: actual pending=%0d expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule